// File: doc/BRIEF.md
# Strap-Sampling Status LED Multiplexer

This block owns a group of ten chip pins: an 8-bit data bus and two strobe lines. While the chip is held in reset, all ten pins are inputs. Board pull resistors set their levels, and the block latches those levels as configuration straps. Once reset has been released and a settling interval has passed, the block turns the pins into outputs. From then on it sends two kinds of status frame in turn, each marked by a rising edge on its own strobe, so external latches can hold the LED states.

The first frame carries per-port link state, with receive activity shown as a stretched blink. The second frame carries packet-buffer fill as a five-step threshold ladder, together with a buffer-alarm flag and a memory-test-failure flag. The data bus changes only halfway between strobe edges, which gives the latch equal setup and hold margins on either side of each edge.

Top module: `status_led_mux`

## Requirements
- R1: While `rst_n` is low, `led_oe`, `led_stb1_o` and `led_stb2_o` are all 0, so every pin is an input.
- R2: `strap_q` holds the pin levels sampled at the last clock edge before internal reset release. Bit 9 comes from strobe 2, bit 8 from strobe 1, and bits 7:0 from the data bus.
- R3: After reset release, changes on `led_data_i`, `led_stb1_i` and `led_stb2_i` leave `strap_q` unchanged.
- R4: `led_oe` rises no earlier than `PERIOD_CYC` clock cycles after `rst_n` rises, and no later than three cycles beyond that. Both strobes stay low until `led_oe` rises.
- R5: Strobe rising edges alternate, starting with strobe 1. Consecutive rising edges are exactly `PERIOD_CYC` cycles apart, and the two strobes are never high together.
- R6: `led_data_o` is stable for at least `PERIOD_CYC/2` cycles before and after every strobe rising edge.
- R7: In the strobe-1 frame, bit i (for i < `NPORT`) is 1 when `port_link[i]` is 1 and port i shows no stretched activity. Bits 7:5 are 0.
- R8: An activity pulse on `port_act[i]`, even one lasting a single cycle, is held as activity for `STRETCH_CYC` cycles. When `STRETCH_CYC` is at least two strobe periods, the pulse appears in the next strobe-1 frame. It clears once the stretch interval has expired.
- R9: In the strobe-2 frame, bit k (k = 0..4) is 1 exactly when `buf_used`*100 >= `buf_total`*P[k], with P = 5, 10, 20, 35, 50.
- R10: In the strobe-2 frame, bit 6 equals `buf_alarm`, bit 7 equals `mem_fail`, and bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| led_data_i | input | 8 | Data pin levels (strap input) |
| led_stb1_i | input | 1 | Strobe 1 pin level (strap input) |
| led_stb2_i | input | 1 | Strobe 2 pin level (strap input) |
| led_data_o | output | 8 | Data pin drive value |
| led_stb1_o | output | 1 | Strobe 1 drive value |
| led_stb2_o | output | 1 | Strobe 2 drive value |
| led_oe | output | 1 | Output enable for all ten pins |
| strap_q | output | 10 | Latched strap bits |
| port_link | input | NPORT | Per-port link up |
| port_act | input | NPORT | Per-port receive activity pulse |
| buf_used | input | CW | Buffers in use |
| buf_total | input | CW | Total buffer capacity |
| buf_alarm | input | 1 | Buffer almost-full alarm |
| mem_fail | input | 1 | External memory test failure |

## Verification
The ladder is driven with used counts one below and exactly at each threshold, both for a round total and for a total that does not divide evenly. This separates a correct `>=` comparison from an off-by-one or truncating comparison. Link and activity patterns use alternating ports and a static activity mask, which shows whether masking works and whether each bit lands in its own position. A single-cycle activity pulse timed just after a strobe-1 edge shows whether the stretcher is present, since without it the pulse would be missed. It also shows that the stretched activity expires in the frame after. Two reset passes with different strap patterns, with the pins changed after release, separate correct sampling-window behaviour from late capture or continued tracking.

// File: rtl/slm_pkg.sv
package slm_pkg;
  localparam int DATA_W    = 8;
  localparam int STRAP_W   = DATA_W + 2;
  localparam int LVL_N     = 5;
  localparam int unsigned LVL_PCT [LVL_N] = '{5, 10, 20, 35, 50};
  localparam int ALARM_POS = 6;
  localparam int MFAIL_POS = 7;
  typedef logic [DATA_W-1:0] frame_t;
endpackage

// File: rtl/slm_act_stretch.sv
module slm_act_stretch #(
  parameter int HOLD_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_s_n,
  input  logic act_i,
  output logic lit_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (act_i)               cnt_d = HW'(HOLD_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign lit_o = (cnt_q != '0);

  // R8: a pulse is visible from the following cycle
  assert_act_visible_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    act_i |=> lit_o);
endmodule

// File: rtl/slm_util_ladder.sv
module slm_util_ladder
  import slm_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic [CW-1:0]    used_i,
  input  logic [CW-1:0]    total_i,
  output logic [LVL_N-1:0] lvl_o
);
  localparam int PW = CW + 7;

  logic [PW-1:0] used_x100;
  assign used_x100 = PW'(used_i) * PW'(100);

  for (genvar k = 0; k < LVL_N; k++) begin : g_step
    assign lvl_o[k] = used_x100 >= (PW'(total_i) * PW'(LVL_PCT[k]));
  end
endmodule

// File: rtl/slm_frame_seq.sv
module slm_frame_seq
  import slm_pkg::*;
#(
  parameter int PERIOD_CYC = 1000
) (
  input  logic   clk,
  input  logic   rst_s_n,
  input  frame_t frame1_i,
  input  frame_t frame2_i,
  output frame_t data_o,
  output logic   stb1_o,
  output logic   stb2_o,
  output logic   oe_o
);
  localparam int CNTW = $clog2(PERIOD_CYC);
  localparam logic [CNTW-1:0] LAST = CNTW'(PERIOD_CYC - 1);
  localparam logic [CNTW-1:0] MID  = CNTW'(PERIOD_CYC / 2);

  logic            en_q, en_d;
  logic            sel_q, sel_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  frame_t          data_q, data_d;
  logic            stb1_q, stb1_d, stb2_q, stb2_d;

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    stb1_d = stb1_q;
    stb2_d = stb2_q;
    if (!en_q) begin
      // settle interval: one full period with pins as inputs
      if (cnt_q == LAST) begin
        en_d  = 1'b1;
        cnt_d = '0;
        sel_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNTW'(1);
      end
    end else begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        sel_d = ~sel_q;
      end else begin
        cnt_d = cnt_q + CNTW'(1);
      end
      if (cnt_q == '0) begin
        data_d = sel_q ? frame2_i : frame1_i;
        stb1_d = 1'b0;
        stb2_d = 1'b0;
      end else if (cnt_q == MID) begin
        stb1_d = ~sel_q;
        stb2_d = sel_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
      stb1_q <= 1'b0;
      stb2_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
      stb1_q <= stb1_d;
      stb2_q <= stb2_d;
    end
  end

  assign data_o = data_q;
  assign stb1_o = stb1_q;
  assign stb2_o = stb2_q;
  assign oe_o   = en_q;

  assert_quiet_until_drive_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en_q |-> (!stb1_q && !stb2_q));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(stb1_q && stb2_q));
  assert_stable_under_strobe_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stb1_q || stb2_q) |-> $stable(data_q));
endmodule

// File: rtl/status_led_mux.sv
module status_led_mux
  import slm_pkg::*;
#(
  parameter int NPORT       = 5,
  parameter int CW          = 11,
  parameter int PERIOD_CYC  = 1000,
  parameter int STRETCH_CYC = 2500000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   led_data_i,
  input  logic                led_stb1_i,
  input  logic                led_stb2_i,
  output logic [DATA_W-1:0]   led_data_o,
  output logic                led_stb1_o,
  output logic                led_stb2_o,
  output logic                led_oe,
  output logic [STRAP_W-1:0]  strap_q,
  input  logic [NPORT-1:0]    port_link,
  input  logic [NPORT-1:0]    port_act,
  input  logic [CW-1:0]       buf_used,
  input  logic [CW-1:0]       buf_total,
  input  logic                buf_alarm,
  input  logic                mem_fail
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // strap capture while internal reset is held
  logic strap_ld;
  assign strap_ld = ~rst_s_n;

  always_ff @(posedge clk) begin
    if (strap_ld) strap_q <= {led_stb2_i, led_stb1_i, led_data_i};
  end

  // per-port activity stretching
  logic [NPORT-1:0] lit;
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    slm_act_stretch #(.HOLD_CYC(STRETCH_CYC)) u_stretch (
      .clk     (clk),
      .rst_s_n (rst_s_n),
      .act_i   (port_act[i]),
      .lit_o   (lit[i])
    );
  end

  logic [LVL_N-1:0] lvl;
  slm_util_ladder #(.CW(CW)) u_ladder (
    .used_i  (buf_used),
    .total_i (buf_total),
    .lvl_o   (lvl)
  );

  frame_t frame1, frame2;
  always_comb begin
    frame1 = '0;
    frame1[NPORT-1:0] = port_link & ~lit;
    frame2 = '0;
    frame2[LVL_N-1:0] = lvl;
    frame2[ALARM_POS] = buf_alarm;
    frame2[MFAIL_POS] = mem_fail;
  end

  slm_frame_seq #(.PERIOD_CYC(PERIOD_CYC)) u_seq (
    .clk      (clk),
    .rst_s_n  (rst_s_n),
    .frame1_i (frame1),
    .frame2_i (frame2),
    .data_o   (led_data_o),
    .stb1_o   (led_stb1_o),
    .stb2_o   (led_stb2_o),
    .oe_o     (led_oe)
  );

  assert_straps_frozen_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    rst_s_n |=> $stable(strap_q));
  assert_ladder_order_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!lvl[1] || lvl[0]) && (!lvl[2] || lvl[1]) && (!lvl[3] || lvl[2]) && (!lvl[4] || lvl[3]));
endmodule

// File: tb/status_led_mux_bench.sv
module status_led_mux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 5;
  localparam int CW    = 11;
  localparam int PER   = 20;
  localparam int HALF  = PER / 2;
  localparam int STR   = 2 * PER;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] led_data_i, led_data_o;
  logic led_stb1_i, led_stb2_i, led_stb1_o, led_stb2_o, led_oe;
  logic [9:0] strap_q;
  logic [NPORT-1:0] port_link, port_act;
  logic [CW-1:0] buf_used, buf_total;
  logic buf_alarm, mem_fail;

  status_led_mux #(.NPORT(NPORT), .CW(CW), .PERIOD_CYC(PER), .STRETCH_CYC(STR)) u_status_led_mux (
    .clk(clk), .rst_n(rst_n),
    .led_data_i(led_data_i), .led_stb1_i(led_stb1_i), .led_stb2_i(led_stb2_i),
    .led_data_o(led_data_o), .led_stb1_o(led_stb1_o), .led_stb2_o(led_stb2_o),
    .led_oe(led_oe), .strap_q(strap_q),
    .port_link(port_link), .port_act(port_act),
    .buf_used(buf_used), .buf_total(buf_total),
    .buf_alarm(buf_alarm), .mem_fail(mem_fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard queues
  logic [7:0] q1[$], q2[$];
  string      t1[$], t2[$];
  int rise1_cnt = 0, rise2_cnt = 0;
  int last_rise = -1, last_chg = 0, last_kind = 0;
  logic p1 = 1'b0, p2 = 1'b0;
  logic [7:0] pd = 8'h00;

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_rise = -1; last_chg = cyc; last_kind = 0;
      p1 = 1'b0; p2 = 1'b0; pd = led_data_o;
    end else begin
      if (led_data_o !== pd) begin
        if (last_rise >= 0) check(cyc - last_rise >= HALF, "R6", "hold cycles after strobe", cyc - last_rise, HALF);
        last_chg = cyc;
      end
      if ((led_stb1_o && !p1) || (led_stb2_o && !p2)) begin
        int kind;
        kind = (led_stb1_o && !p1) ? 1 : 2;
        check(cyc - last_chg >= HALF, "R6", "setup cycles before strobe", cyc - last_chg, HALF);
        if (last_rise >= 0) begin
          check(cyc - last_rise == PER, "R5", "strobe spacing", cyc - last_rise, PER);
          check(kind != last_kind, "R5", "strobe alternation", kind, 3 - last_kind);
        end else begin
          check(kind == 1, "R5", "first strobe is strobe 1", kind, 1);
        end
        last_rise = cyc; last_kind = kind;
        if (kind == 1) begin
          rise1_cnt++;
          if (q1.size() != 0) begin
            logic [7:0] e; string tg;
            e = q1.pop_front(); tg = t1.pop_front();
            check(led_data_o == e, tg, "strobe-1 frame", int'(led_data_o), int'(e));
          end
        end else begin
          rise2_cnt++;
          if (q2.size() != 0) begin
            logic [7:0] e; string tg;
            e = q2.pop_front(); tg = t2.pop_front();
            check(led_data_o == e, tg, "strobe-2 frame", int'(led_data_o), int'(e));
          end
        end
      end
      p1 = led_stb1_o; p2 = led_stb2_o; pd = led_data_o;
    end
  end

  function automatic logic [4:0] ladder(input int used, input int total);
    int pct[5] = '{5, 10, 20, 35, 50};
    logic [4:0] r;
    for (int k = 0; k < 5; k++) r[k] = (used * 100 >= total * pct[k]);
    return r;
  endfunction

  task automatic wait_drain();
    while (q1.size() != 0 || q2.size() != 0) @(negedge clk);
  endtask

  // driver: set inputs, let two frames of each kind pass, then queue expectations
  task automatic apply(input logic [4:0] link, input logic [4:0] act, input int used, input int total,
                       input logic alarm, input logic fail, input string tag1, input string tag2);
    int b1, b2;
    port_link = link; port_act = act;
    buf_used = CW'(used); buf_total = CW'(total);
    buf_alarm = alarm; mem_fail = fail;
    b1 = rise1_cnt; b2 = rise2_cnt;
    while (rise1_cnt < b1 + 2 || rise2_cnt < b2 + 2) @(negedge clk);
    q1.push_back({3'b000, link & ~act}); t1.push_back(tag1);
    q2.push_back({fail, alarm, 1'b0, ladder(used, total)}); t2.push_back(tag2);
    wait_drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    int n;
    bit strobe_bad;
    rst_n = 1'b0;
    led_data_i = 8'hA5; led_stb1_i = 1'b0; led_stb2_i = 1'b1;
    port_link = '0; port_act = '0; buf_used = '0; buf_total = CW'(1000);
    buf_alarm = 1'b0; mem_fail = 1'b0;
    repeat (5) @(negedge clk);
    check(led_oe == 1'b0, "R1", "oe in reset", int'(led_oe), 0);
    check({led_stb2_o, led_stb1_o} == 2'b00, "R1", "strobes in reset", int'({led_stb2_o, led_stb1_o}), 0);

    rst_n = 1'b1;
    n = 0; strobe_bad = 1'b0;
    while (!led_oe && n < 4 * PER) begin
      @(negedge clk);
      n++;
      if (!led_oe && (led_stb1_o || led_stb2_o)) strobe_bad = 1'b1;
      if (n == 4) begin
        check(strap_q == 10'h2A5, "R2", "strap capture", int'(strap_q), 'h2A5);
        led_data_i = 8'h5A; led_stb1_i = 1'b1; led_stb2_i = 1'b0;
      end
    end
    check(n >= PER && n <= PER + 3, "R4", "cycles until drive", n, PER + 2);
    check(!strobe_bad, "R4", "strobes quiet before drive", int'(strobe_bad), 0);
    check(strap_q == 10'h2A5, "R3", "straps after pin change", int'(strap_q), 'h2A5);

    apply(5'b11111, 5'b00000,    0, 1000, 1'b0, 1'b0, "R7", "R9");
    apply(5'b10101, 5'b00100,   50, 1000, 1'b1, 1'b0, "R7", "R10");
    apply(5'b01010, 5'b00000,   49, 1000, 1'b0, 1'b1, "R7", "R10");
    apply(5'b11111, 5'b10001,  200, 1000, 1'b0, 1'b0, "R7", "R9");
    apply(5'b11111, 5'b00000,  199, 1000, 1'b0, 1'b0, "R7", "R9");
    apply(5'b11111, 5'b00000,  350, 1000, 1'b0, 1'b0, "R7", "R9");
    apply(5'b11111, 5'b00000,  349, 1000, 1'b0, 1'b0, "R7", "R9");
    apply(5'b11111, 5'b00000,  500, 1000, 1'b1, 1'b1, "R7", "R10");
    apply(5'b00000, 5'b00000,   68, 1365, 1'b0, 1'b0, "R7", "R9");
    apply(5'b00000, 5'b00000,   69, 1365, 1'b0, 1'b0, "R7", "R9");
    apply(5'b11111, 5'b00000, 1365, 1365, 1'b0, 1'b0, "R7", "R9");

    // single-cycle activity pulse just after a strobe-1 edge
    begin
      int b;
      b = rise1_cnt;
      while (rise1_cnt == b) @(negedge clk);
      port_act = 5'b00100;
      @(negedge clk);
      port_act = 5'b00000;
      q1.push_back(8'h1B); t1.push_back("R8");
      q1.push_back(8'h1F); t1.push_back("R8");
      wait_drain();
    end

    // second reset pass with a different strap pattern
    rst_n = 1'b0;
    led_data_i = 8'hF3; led_stb1_i = 1'b0; led_stb2_i = 1'b0;
    @(negedge clk);
    check(led_oe == 1'b0, "R1", "oe after reset asserted", int'(led_oe), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(strap_q == 10'h0F3, "R2", "strap recapture", int'(strap_q), 'h0F3);
    led_data_i = 8'h00; led_stb2_i = 1'b1;
    repeat (3) @(negedge clk);
    check(strap_q == 10'h0F3, "R3", "straps after second change", int'(strap_q), 'h0F3);

    summary();
    $finish;
  end
endmodule